// File: doc/BRIEF.md
# Blocking Coprocessor Register Front End

This block lets a processor drive a small compute kernel through memory-mapped registers on an AXI4-Lite slave port. Software loads two operand registers and writes a start bit. It then polls a completion flag and reads a result register once the flag is set. The wrapper is the bus slave and the processor is the master. Every control action and every data transfer goes through the register interface.

The control registers provide a self-clearing soft reset, a kernel enable that is on after bus reset, a self-clearing start bit, and a read-only completion flag. The kernel here is a stub. It latches the two operands when it starts, computes the second operand minus the first modulo 2^DATA_W, and signals completion a parameterised number of cycles later. A start request is dropped while the kernel is disabled. A soft reset clears the result and the completion flag but keeps the operands and the enable setting.

Top module: `axil_blocking_coproc`

## Requirements
- R1: After bus reset (aresetn low), the enable register (byte offset 0x4, bit 0) reads 1, the completion flag (0xC, bit 0) reads 0, and the operand registers (0x100 first operand, 0x104 second operand) and the result register (0x108) all read 0.
- R2: A write completes whether its address and data arrive together, address first or data first. Exactly one write response is given per write, with bresp = 0 (OKAY), and bvalid stays high until bready is seen.
- R3: A write to an operand register updates only the byte lanes whose wstrb bit is 1. Byte lane k is wdata bits [8k+7:8k].
- R4: A read returns 0 with rresp = 0 (OKAY) for any unmapped or misaligned address and for the soft-reset (0x0) and start (0x8) offsets. The enable and completion registers read back their state in bit 0 with zeros above.
- R5: While enabled, writing 1 to bit 0 of offset 0x8 (lane 0 strobed) clears the completion flag at once. The flag then sets KERNEL_LAT+2 clock edges after the edge that raises bvalid for that write. At that point the result register holds second operand minus first, modulo 2^DATA_W.
- R6: Writing 0 to bit 0 of offset 0x4 disables the kernel. A start write while disabled clears the completion flag and starts nothing, so the flag stays 0 and the result is unchanged.
- R7: Writing 1 to bit 0 of offset 0x0 pulses an internal soft reset for exactly one cycle. It clears the result register, the completion flag and any kernel pass in progress, and it leaves the operand and enable registers unchanged.
- R8: The result register is read-only: a write to 0x108 changes no register.
- R9: Only one read is outstanding at a time. arready is low while rvalid is high, and rvalid stays high until rready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous bus reset |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_awaddr | input | ADDR_W | Write byte address |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_wdata | input | DATA_W | Write data |
| s_axi_wstrb | input | DATA_W/8 | Write byte-lane enables |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_bresp | output | 2 | Write response code, always OKAY |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_araddr | input | ADDR_W | Read byte address |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data ready |
| s_axi_rdata | output | DATA_W | Read data |
| s_axi_rresp | output | 2 | Read response code, always OKAY |

## Verification
A write takes effect at the edge that raises bvalid. Read data is taken from the registers at the read-address handshake edge. The completion flag rises KERNEL_LAT+2 edges after a start write's bvalid edge. The bench therefore reads the flag straight after a start response and expects 0. It then waits well past the full latency and expects 1 before it reads and checks the result. The exact latency of the kernel's done pulse and of the flag is checked cycle by cycle by a counter in the checker module. The operand sweep covers signed extremes, zero and wraparound pairs, and rotates the address/data ordering on every write.

// File: rtl/coproc_pkg.sv
package coproc_pkg;

   localparam logic [31:0] OFF_SOFT_RST = 32'h0000_0000;
   localparam logic [31:0] OFF_ENABLE   = 32'h0000_0004;
   localparam logic [31:0] OFF_START    = 32'h0000_0008;
   localparam logic [31:0] OFF_DONE     = 32'h0000_000C;
   localparam logic [31:0] OFF_OPND_A   = 32'h0000_0100;
   localparam logic [31:0] OFF_OPND_B   = 32'h0000_0104;
   localparam logic [31:0] OFF_RESULT   = 32'h0000_0108;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SOFT_RST,
      SEL_ENABLE,
      SEL_START,
      SEL_DONE,
      SEL_OPND_A,
      SEL_OPND_B,
      SEL_RESULT
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
      reg_sel_e sel;
      case (byte_addr)
         OFF_SOFT_RST: sel = SEL_SOFT_RST;
         OFF_ENABLE:   sel = SEL_ENABLE;
         OFF_START:    sel = SEL_START;
         OFF_DONE:     sel = SEL_DONE;
         OFF_OPND_A:   sel = SEL_OPND_A;
         OFF_OPND_B:   sel = SEL_OPND_B;
         OFF_RESULT:   sel = SEL_RESULT;
         default:      sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/cp_wr_channel.sv
module cp_wr_channel #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awvalid,
   output logic              awready,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              wvalid,
   output logic              wready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb
);

   logic              aw_held_q;
   logic              w_held_q;
   logic              bvalid_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [STRB_W-1:0] strb_q;

   assign awready = !aw_held_q && !bvalid_q;
   assign wready  = !w_held_q && !bvalid_q;
   assign wr_en   = aw_held_q && w_held_q && !bvalid_q;
   assign wr_addr = addr_q;
   assign wr_data = data_q;
   assign wr_strb = strb_q;
   assign bvalid  = bvalid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held_q <= 1'b0;
         w_held_q  <= 1'b0;
         bvalid_q  <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
         strb_q    <= '0;
      end else begin
         if (awvalid && awready) begin
            aw_held_q <= 1'b1;
            addr_q    <= awaddr;
         end
         if (wvalid && wready) begin
            w_held_q <= 1'b1;
            data_q   <= wdata;
            strb_q   <= wstrb;
         end
         if (wr_en) begin
            aw_held_q <= 1'b0;
            w_held_q  <= 1'b0;
            bvalid_q  <= 1'b1;
         end else if (bvalid_q && bready) begin
            bvalid_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cp_rd_channel.sv
module cp_rd_channel #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arvalid,
   output logic              arready,
   input  logic [ADDR_W-1:0] araddr,
   output logic              rvalid,
   input  logic              rready,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_value
);

   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   assign arready = !rvalid_q;
   assign rvalid  = rvalid_q;
   assign rdata   = rdata_q;
   assign rd_addr = araddr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (arvalid && arready) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_value;
      end else if (rvalid_q && rready) begin
         rvalid_q <= 1'b0;
      end
   end

endmodule

// File: rtl/cp_sub_kernel.sv
module cp_sub_kernel #(
   parameter int DATA_W = 32,
   parameter int LAT    = 4,
   localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              done,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] res_q;
   logic              done_q;

   assign done   = done_q;
   assign result = res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (start) begin
         res_q <= opnd_b - opnd_a;
      end
   end

   generate
      if (LAT == 1) begin : g_single
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               pend_q <= 1'b0;
               done_q <= 1'b0;
            end else begin
               pend_q <= start;
               done_q <= pend_q && !start;
            end
         end
      end else begin : g_count
         logic             busy_q;
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b0;
               if (start) begin
                  busy_q <= 1'b1;
                  cnt_q  <= CNT_W'(LAT);
               end else if (busy_q) begin
                  if (cnt_q == CNT_W'(1)) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cp_reg_bank.sv
module cp_reg_bank
   import coproc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_value,
   input  logic              k_done,
   input  logic [DATA_W-1:0] k_result,
   output logic              k_start,
   output logic              soft_rst,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b,
   output logic              enable,
   output logic              ready,
   output logic [DATA_W-1:0] result
);

   localparam int PAD_W = 32 - ADDR_W;

   reg_sel_e          wsel;
   reg_sel_e          rsel;
   logic              bit0_write;
   logic              go_write;
   logic [DATA_W-1:0] a_q, b_q, out_q;
   logic [DATA_W-1:0] a_nxt, b_nxt;
   logic              en_q, rdy_q, srst_q, start_q;

   assign wsel       = decode_addr({{PAD_W{1'b0}}, wr_addr});
   assign rsel       = decode_addr({{PAD_W{1'b0}}, rd_addr});
   assign bit0_write = wr_en && wr_strb[0];
   assign go_write   = bit0_write && (wsel == SEL_START) && wr_data[0];

   generate
      for (genvar g = 0; g < STRB_W; g++) begin : g_lane
         assign a_nxt[8*g +: 8] = wr_strb[g] ? wr_data[8*g +: 8] : a_q[8*g +: 8];
         assign b_nxt[8*g +: 8] = wr_strb[g] ? wr_data[8*g +: 8] : b_q[8*g +: 8];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         en_q    <= 1'b1;
         srst_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         srst_q  <= bit0_write && (wsel == SEL_SOFT_RST) && wr_data[0];
         start_q <= go_write && en_q;
         if (bit0_write && wsel == SEL_ENABLE) begin
            en_q <= wr_data[0];
         end
         if (wr_en && wsel == SEL_OPND_A) begin
            a_q <= a_nxt;
         end
         if (wr_en && wsel == SEL_OPND_B) begin
            b_q <= b_nxt;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || srst_q) begin
         rdy_q <= 1'b0;
         out_q <= '0;
      end else if (go_write) begin
         rdy_q <= 1'b0;
      end else if (k_done) begin
         rdy_q <= 1'b1;
         out_q <= k_result;
      end
   end

   always_comb begin
      rd_value = '0;
      case (rsel)
         SEL_ENABLE: rd_value[0] = en_q;
         SEL_DONE:   rd_value[0] = rdy_q;
         SEL_OPND_A: rd_value    = a_q;
         SEL_OPND_B: rd_value    = b_q;
         SEL_RESULT: rd_value    = out_q;
         default:    rd_value    = '0;
      endcase
   end

   assign k_start  = start_q;
   assign soft_rst = srst_q;
   assign opnd_a   = a_q;
   assign opnd_b   = b_q;
   assign enable   = en_q;
   assign ready    = rdy_q;
   assign result   = out_q;

endmodule

// File: rtl/axil_blocking_coproc.sv
module axil_blocking_coproc
   import coproc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int KERNEL_LAT = 4,
   localparam int STRB_W    = DATA_W / 8
) (
   input  logic              aclk,
   input  logic              aresetn,
   input  logic              s_axi_awvalid,
   output logic              s_axi_awready,
   input  logic [ADDR_W-1:0] s_axi_awaddr,
   input  logic              s_axi_wvalid,
   output logic              s_axi_wready,
   input  logic [DATA_W-1:0] s_axi_wdata,
   input  logic [STRB_W-1:0] s_axi_wstrb,
   output logic              s_axi_bvalid,
   input  logic              s_axi_bready,
   output logic [1:0]        s_axi_bresp,
   input  logic              s_axi_arvalid,
   output logic              s_axi_arready,
   input  logic [ADDR_W-1:0] s_axi_araddr,
   output logic              s_axi_rvalid,
   input  logic              s_axi_rready,
   output logic [DATA_W-1:0] s_axi_rdata,
   output logic [1:0]        s_axi_rresp
);

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
         $error("DATA_W must be 32 or 64");
      end
      if (ADDR_W < 9 || ADDR_W > 31) begin : g_bad_addr_w
         $error("ADDR_W must lie in 9..31 to reach the data registers");
      end
      if (KERNEL_LAT < 1 || KERNEL_LAT > 255) begin : g_bad_lat
         $error("KERNEL_LAT must lie in 1..255");
      end
   endgenerate

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [STRB_W-1:0] wr_strb;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_value;
   logic              k_start, k_done, soft_rst;
   logic [DATA_W-1:0] k_result, opnd_a, opnd_b, result_val;
   logic              enable_flag, ready_flag;

   assign s_axi_bresp = RESP_OKAY;
   assign s_axi_rresp = RESP_OKAY;

   cp_wr_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk     (aclk),
      .rst_n   (aresetn),
      .awvalid (s_axi_awvalid),
      .awready (s_axi_awready),
      .awaddr  (s_axi_awaddr),
      .wvalid  (s_axi_wvalid),
      .wready  (s_axi_wready),
      .wdata   (s_axi_wdata),
      .wstrb   (s_axi_wstrb),
      .bvalid  (s_axi_bvalid),
      .bready  (s_axi_bready),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_strb (wr_strb)
   );

   cp_rd_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk      (aclk),
      .rst_n    (aresetn),
      .arvalid  (s_axi_arvalid),
      .arready  (s_axi_arready),
      .araddr   (s_axi_araddr),
      .rvalid   (s_axi_rvalid),
      .rready   (s_axi_rready),
      .rdata    (s_axi_rdata),
      .rd_addr  (rd_addr),
      .rd_value (rd_value)
   );

   cp_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (aclk),
      .rst_n    (aresetn),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .wr_strb  (wr_strb),
      .rd_addr  (rd_addr),
      .rd_value (rd_value),
      .k_done   (k_done),
      .k_result (k_result),
      .k_start  (k_start),
      .soft_rst (soft_rst),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .enable   (enable_flag),
      .ready    (ready_flag),
      .result   (result_val)
   );

   cp_sub_kernel #(.DATA_W(DATA_W), .LAT(KERNEL_LAT)) u_kernel (
      .clk    (aclk),
      .rst_n  (aresetn),
      .clr    (soft_rst),
      .start  (k_start),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .done   (k_done),
      .result (k_result)
   );

endmodule

// File: rtl/coproc_checker.sv
module coproc_checker #(
   parameter int LAT    = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bvalid,
   input logic              bready,
   input logic              awready,
   input logic              wready,
   input logic [1:0]        bresp,
   input logic              rvalid,
   input logic              rready,
   input logic              arready,
   input logic [1:0]        rresp,
   input logic              k_start,
   input logic              k_done,
   input logic              soft_rst,
   input logic              enable_flag,
   input logic              ready_flag,
   input logic [DATA_W-1:0] result_val
);

   logic [15:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         run_cnt <= '0;
      end else if (k_start) begin
         run_cnt <= 16'd1;
      end else if (run_cnt != 16'd0 && run_cnt != 16'hFFFF) begin
         run_cnt <= run_cnt + 16'd1;
      end
   end

   // R2: response held until accepted
   a_r2_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid);
   // R2: no new write accepted while a response is pending
   a_r2_no_accept_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid |-> !awready && !wready);
   // R2 / R4: both response codes are OKAY
   a_r4_resp_okay: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));
   // R9: one read outstanding, data held until accepted
   a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> !arready);
   a_r9_rvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid);
   // R5: kernel completes exactly LAT cycles after taking the start
   a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      k_done |-> run_cnt == 16'(LAT + 1));
   // R5: completion flag only rises after a kernel done pulse
   a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_flag) |-> $past(k_done));
   // R6: no kernel start while disabled
   a_r6_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      k_start |-> enable_flag);
   // R7: soft reset is a single-cycle pulse that clears flag and result
   a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);
   a_r7_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !ready_flag && result_val == '0);

endmodule

bind axil_blocking_coproc coproc_checker #(.LAT(KERNEL_LAT), .DATA_W(DATA_W)) u_chk (
   .clk         (aclk),
   .rst_n       (aresetn),
   .bvalid      (s_axi_bvalid),
   .bready      (s_axi_bready),
   .awready     (s_axi_awready),
   .wready      (s_axi_wready),
   .bresp       (s_axi_bresp),
   .rvalid      (s_axi_rvalid),
   .rready      (s_axi_rready),
   .arready     (s_axi_arready),
   .rresp       (s_axi_rresp),
   .k_start     (k_start),
   .k_done      (k_done),
   .soft_rst    (soft_rst),
   .enable_flag (enable_flag),
   .ready_flag  (ready_flag),
   .result_val  (result_val)
);

// File: tb/axil_blocking_coproc_bench.sv
`timescale 1ns/1ps
module axil_blocking_coproc_bench;

   localparam int AW = 12;
   localparam int DW = 32;

   logic          aclk = 1'b0;
   logic          aresetn = 1'b0;
   logic          awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
   logic          arvalid = 1'b0, rready = 1'b0;
   logic [AW-1:0] awaddr = '0, araddr = '0;
   logic [DW-1:0] wdata = '0;
   logic [3:0]    wstrb = '0;
   logic          awready, wready, bvalid, arready, rvalid;
   logic [1:0]    bresp, rresp;
   logic [DW-1:0] rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #2.5 aclk = ~aclk;

   axil_blocking_coproc #(.ADDR_W(AW), .DATA_W(DW), .KERNEL_LAT(4)) u_axil_blocking_coproc (
      .aclk          (aclk),
      .aresetn       (aresetn),
      .s_axi_awvalid (awvalid),
      .s_axi_awready (awready),
      .s_axi_awaddr  (awaddr),
      .s_axi_wvalid  (wvalid),
      .s_axi_wready  (wready),
      .s_axi_wdata   (wdata),
      .s_axi_wstrb   (wstrb),
      .s_axi_bvalid  (bvalid),
      .s_axi_bready  (bready),
      .s_axi_bresp   (bresp),
      .s_axi_arvalid (arvalid),
      .s_axi_arready (arready),
      .s_axi_araddr  (araddr),
      .s_axi_rvalid  (rvalid),
      .s_axi_rready  (rready),
      .s_axi_rdata   (rdata),
      .s_axi_rresp   (rresp)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // ord: 0 address and data together, 1 address first, 2 data first
   task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                            input logic [3:0] s, input int ord);
      bit aw_ok, w_ok;
      @(negedge aclk);
      if (ord != 2) begin awvalid = 1'b1; awaddr = a; end
      if (ord != 1) begin wvalid = 1'b1; wdata = d; wstrb = s; end
      aw_ok = 1'b0;
      w_ok  = 1'b0;
      while (!(aw_ok && w_ok)) begin
         bit aw_hs, w_hs;
         aw_hs = awvalid && awready;
         w_hs  = wvalid && wready;
         @(negedge aclk);
         if (aw_hs) begin awvalid = 1'b0; aw_ok = 1'b1; end
         if (w_hs)  begin wvalid = 1'b0;  w_ok = 1'b1;  end
         if (ord == 1 && aw_ok && !w_ok && !wvalid) begin
            wvalid = 1'b1; wdata = d; wstrb = s;
         end
         if (ord == 2 && w_ok && !aw_ok && !awvalid) begin
            awvalid = 1'b1; awaddr = a;
         end
      end
      bready = 1'b1;
      while (!bvalid) @(negedge aclk);
      check("R2 bresp", {30'd0, bresp}, 32'd0);
      @(negedge aclk);
      bready = 1'b0;
      check("R2 single response", {31'd0, bvalid}, 32'd0);
   endtask

   task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] d);
      bit ok;
      @(negedge aclk);
      arvalid = 1'b1;
      araddr  = a;
      ok = 1'b0;
      while (!ok) begin
         ok = arready;
         @(negedge aclk);
      end
      arvalid = 1'b0;
      rready  = 1'b1;
      while (!rvalid) @(negedge aclk);
      d = rdata;
      check("R9 rresp", {30'd0, rresp}, 32'd0);
      @(negedge aclk);
      rready = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      axi_read(a, v);
      check(req, v, exp);
   endtask

   initial begin
      logic [31:0] opv [6];
      logic [31:0] last_out;
      opv[0] = 32'h0000_0000; opv[1] = 32'h0000_0001; opv[2] = 32'h7FFF_FFFF;
      opv[3] = 32'h8000_0000; opv[4] = 32'hFFFF_FFFF; opv[5] = 32'h1234_5678;

      repeat (4) @(negedge aclk);
      aresetn = 1'b1;

      // R1 reset state
      expect_reg("R1 enable", 12'h004, 32'd1);
      expect_reg("R1 done flag", 12'h00C, 32'd0);
      expect_reg("R1 operand a", 12'h100, 32'd0);
      expect_reg("R1 operand b", 12'h104, 32'd0);
      expect_reg("R1 result", 12'h108, 32'd0);

      // R4 unmapped, misaligned and write-only offsets
      expect_reg("R4 unmapped 0x200", 12'h200, 32'd0);
      expect_reg("R4 unmapped 0x010", 12'h010, 32'd0);
      expect_reg("R4 misaligned 0x101", 12'h101, 32'd0);
      expect_reg("R4 soft reset reads 0", 12'h000, 32'd0);
      expect_reg("R4 start reads 0", 12'h008, 32'd0);

      // R3 byte lanes
      axi_write(12'h100, 32'h0000_0000, 4'hF, 0);
      axi_write(12'h100, 32'hAABB_CCDD, 4'b0101, 1);
      expect_reg("R3 lanes 0 and 2", 12'h100, 32'h00BB_00DD);
      axi_write(12'h100, 32'h1122_3344, 4'b1000, 2);
      expect_reg("R3 lane 3", 12'h100, 32'h11BB_00DD);

      // R5 near-exhaustive operand sweep, write ordering rotated (R2)
      last_out = 32'd0;
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            axi_write(12'h100, opv[i], 4'hF, (i + j) % 3);
            axi_write(12'h104, opv[j], 4'hF, (i + j + 1) % 3);
            axi_write(12'h008, 32'd1, 4'h1, (i + j + 2) % 3);
            expect_reg("R5 flag cleared by start", 12'h00C, 32'd0);
            repeat (12) @(negedge aclk);
            expect_reg("R5 flag set after pass", 12'h00C, 32'd1);
            last_out = opv[j] - opv[i];
            expect_reg("R5 result b minus a", 12'h108, last_out);
         end
      end

      // R8 result is read-only
      axi_write(12'h108, 32'hDEAD_BEEF, 4'hF, 0);
      expect_reg("R8 result unchanged", 12'h108, last_out);
      expect_reg("R8 operand a unchanged", 12'h100, opv[5]);

      // R6 disabled kernel ignores start
      axi_write(12'h100, 32'd10, 4'hF, 0);
      axi_write(12'h104, 32'd3, 4'hF, 0);
      axi_write(12'h004, 32'd0, 4'h1, 1);
      expect_reg("R6 enable reads 0", 12'h004, 32'd0);
      axi_write(12'h008, 32'd1, 4'h1, 0);
      repeat (12) @(negedge aclk);
      expect_reg("R6 flag stays 0", 12'h00C, 32'd0);
      expect_reg("R6 result unchanged", 12'h108, last_out);
      axi_write(12'h004, 32'd1, 4'h1, 2);
      axi_write(12'h008, 32'd1, 4'h1, 0);
      repeat (12) @(negedge aclk);
      expect_reg("R6 re-enabled pass", 12'h108, 32'hFFFF_FFF9);

      // R7 soft reset
      axi_write(12'h000, 32'd1, 4'h1, 0);
      expect_reg("R7 soft reset self-clears", 12'h000, 32'd0);
      expect_reg("R7 flag cleared", 12'h00C, 32'd0);
      expect_reg("R7 result cleared", 12'h108, 32'd0);
      expect_reg("R7 operand a kept", 12'h100, 32'd10);
      expect_reg("R7 operand b kept", 12'h104, 32'd3);
      expect_reg("R7 enable kept", 12'h004, 32'd1);

      // R7 soft reset aborts a pass in progress
      axi_write(12'h008, 32'd1, 4'h1, 0);
      axi_write(12'h000, 32'd1, 4'h1, 0);
      repeat (12) @(negedge aclk);
      expect_reg("R7 aborted pass leaves flag 0", 12'h00C, 32'd0);
      expect_reg("R7 aborted pass leaves result 0", 12'h108, 32'd0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge aclk);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule